// File: doc/BRIEF.md
# Sequenced-refresh watchdog timer

The block is a watchdog with five 16-bit registers on a simple write/read port. Once enabled it counts down in half-second steps, paced by a slow tick pulse, and cannot be stopped. Software keeps it from expiring by writing the word 0x5555 and then the word 0xAAAA to the service register. If the countdown runs out, the block drives either an internal reset request or an active-low external reset pin for a fixed number of ticks, and it records the cause in a status register.

A pre-timeout interrupt can be set to fire a chosen number of half-seconds before expiry. Software can also request either reset directly by writing a zero to one of two control bits. A low-power input can freeze the countdown when the suspend bit was set by the first control write. A power-down counter that is on out of reset pulses the external pin low for one clock unless software turns it off.

Register offsets: 0x0 control, 0x2 service, 0x4 status, 0x6 interrupt control, 0x8 misc. Other addresses read as zero and ignore writes.

Top module: `wdog_timer`

## Requirements
- R1: Out of reset, control reads 0x0030, service, status and interrupt control read 0x0000, misc reads 0x0001, `rst_int_o` is 0, `rst_ext_n` is 1 and `irq` is 0.
- R2: Control bits 15:8 (T) set the period. With control bit 3 at 0, `rst_int_o` rises after (T+1)*TICKS_PER_HALF ticks, counted from the write that sets enable bit 2 or from a service reload.
- R3: A service write of 0xAAAA that directly follows a service write of 0x5555 reloads the countdown to the full period.
- R4: Any other service write (a wrong word, or 0xAAAA not directly after 0x5555) clears the sequence and does not reload.
- R5: Enable bit 2 stays set once written as 1. Later control writes with bit 2 at 0 neither clear it nor stop the countdown.
- R6: Status bit 1 is set (and bit 0 cleared) on a timeout. Status bit 0 is set (and bit 1 cleared) on a software reset request. The update happens when the reset output asserts.
- R7: With control bit 3 at 1, a timeout drives only `rst_ext_n` low and leaves `rst_int_o` at 0.
- R8: A control write with bit 4 at 0 asserts `rst_int_o`, and one with bit 5 at 0 drives `rst_ext_n` low, on the cycle after the write. Both bits always read back as 1.
- R9: A reset output, once asserted, stays asserted for exactly HOLD_TICKS ticks.
- R10: With interrupt control bit 15 set, status bit 14 and `irq` rise when the remaining count reaches bits 7:0 (P), that is after (T-P)*TICKS_PER_HALF ticks. Writing 1 to bit 14 clears it. With bit 15 at 0, `irq` stays low.
- R11: Control bit 0 takes its value only from the first control write after reset. While it is 1 and `lp_mode` is high, the countdown is frozen.
- R12: A new T written while the timer runs does not change the running countdown. It takes effect at the next reload.
- R13: Unless misc bit 0 is written as 0 first, `rst_ext_n` goes low for exactly one clock after PDN_TICKS ticks from reset. Once cleared, the bit cannot be set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock pulse from the slow timebase |
| lp_mode | input | 1 | Low-power mode indication |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rst_int_o | output | 1 | Internal reset request, active high |
| rst_ext_n | output | 1 | External reset pin, active low |
| irq | output | 1 | Pre-timeout interrupt |

## Verification
On every cycle the assertions check four things. The enable bit and the locked suspend bit never change back. A completed service pair reloads the counter. Nothing moves while the counter is frozen. Each timeout lands in the status register and on the reset path chosen by the action bit.

Only the bench's scenarios can show the absolute tick counts. These are the expiry period, the interrupt lead time, the length of the reset hold, the delayed effect of a new period, the rejection of broken service sequences and the single-clock power-down pulse.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int TICKS_PER_HALF = 16384,
  parameter int HOLD_TICKS     = 4,
  parameter int PDN_TICKS      = 524288
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        lp_mode,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rst_int_o,
  output logic        rst_ext_n,
  output logic        irq
);
  localparam int PW = $clog2(TICKS_PER_HALF);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int DW = $clog2(PDN_TICKS + 1);

  logic [7:0]    tmo, cnt, lead;
  logic          act_ext, en, lp_susp, lp_locked, armed;
  logic          ie, isr, pdn_en, pdn_pulse;
  logic [1:0]    cause;
  logic [PW-1:0] pre;
  logic [HW-1:0] ihold, ehold;
  logic [DW-1:0] pdn_cnt;

  wire wr_ctl  = bus_wr && bus_addr == 4'h0;
  wire wr_svc  = bus_wr && bus_addr == 4'h2;
  wire wr_icr  = bus_wr && bus_addr == 4'h6;
  wire wr_misc = bus_wr && bus_addr == 4'h8;

  wire svc_ok  = wr_svc && bus_wdata == 16'hAAAA && armed;
  wire start   = wr_ctl && bus_wdata[2] && !en;
  wire load    = start || svc_ok;
  wire run     = en && !(lp_susp && lp_mode);
  wire half    = run && tick && pre == PW'(TICKS_PER_HALF - 1) && !load;
  wire expire  = half && cnt == 8'd0;
  wire sw_int  = wr_ctl && !bus_wdata[4];
  wire sw_ext  = wr_ctl && !bus_wdata[5];
  wire lead_hit = half && cnt != 8'd0 && (cnt - 8'd1) == lead && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo <= '0; act_ext <= 1'b0; en <= 1'b0; lp_susp <= 1'b0; lp_locked <= 1'b0;
      armed <= 1'b0; cnt <= '0; pre <= '0;
    end else begin
      if (wr_ctl) begin
        tmo       <= bus_wdata[15:8];
        act_ext   <= bus_wdata[3];
        en        <= en | bus_wdata[2];
        lp_locked <= 1'b1;
        if (!lp_locked) lp_susp <= bus_wdata[0];
      end
      if (wr_svc) armed <= (bus_wdata == 16'h5555);
      if (load) begin
        cnt <= start ? bus_wdata[15:8] : tmo;
        pre <= '0;
      end else if (half) begin
        pre <= '0;
        cnt <= (cnt == 8'd0) ? tmo : cnt - 8'd1;
      end else if (run && tick) begin
        pre <= pre + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= 1'b0; isr <= 1'b0; lead <= '0;
    end else begin
      if (wr_icr) begin
        ie   <= bus_wdata[15];
        lead <= bus_wdata[7:0];
      end
      if (lead_hit) isr <= 1'b1;
      else if (wr_icr && bus_wdata[14]) isr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ihold <= '0; ehold <= '0; cause <= '0;
    end else begin
      if ((expire && !act_ext) || sw_int) ihold <= HW'(HOLD_TICKS);
      else if (tick && ihold != '0)       ihold <= ihold - HW'(1);
      if ((expire && act_ext) || sw_ext)  ehold <= HW'(HOLD_TICKS);
      else if (tick && ehold != '0)       ehold <= ehold - HW'(1);
      if (expire)                cause <= 2'b10;
      else if (sw_int || sw_ext) cause <= 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_en <= 1'b1; pdn_cnt <= '0; pdn_pulse <= 1'b0;
    end else begin
      if (wr_misc) pdn_en <= pdn_en & bus_wdata[0];
      if (tick && pdn_cnt != DW'(PDN_TICKS)) pdn_cnt <= pdn_cnt + DW'(1);
      pdn_pulse <= tick && pdn_en && pdn_cnt == DW'(PDN_TICKS - 1);
    end
  end

  assign rst_int_o = ihold != '0;
  assign rst_ext_n = (ehold == '0) && !pdn_pulse;
  assign irq       = isr && ie;

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = {tmo, 2'b00, 2'b11, act_ext, en, 1'b0, lp_susp};
      4'h4:    bus_rdata = {14'd0, cause};
      4'h6:    bus_rdata = {ie, isr, 6'd0, lead};
      4'h8:    bus_rdata = {15'd0, pdn_en};
      default: bus_rdata = 16'h0000;
    endcase
  end

  // R5
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) en |=> en);
  // R11
  lp_once_chk: assert property (@(posedge clk) disable iff (!rst_n) lp_locked |=> $stable(lp_susp));
  // R11
  lp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && lp_susp && !bus_wr) |=> ($stable(cnt) && $stable(pre)));
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> (cnt == $past(tmo) && pre == '0));
  // R6
  tout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) expire |=> cause == 2'b10);
  // R2
  int_path_chk: assert property (@(posedge clk) disable iff (!rst_n) (expire && !act_ext) |=> rst_int_o);
  // R7
  ext_path_chk: assert property (@(posedge clk) disable iff (!rst_n) (expire && act_ext) |=> !rst_ext_n);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(isr) |-> $past(ie));
  // R9
  hold_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ihold <= HW'(HOLD_TICKS) && ehold <= HW'(HOLD_TICKS)));
endmodule

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  localparam int TPH = 4, HOLD = 3, PDN = 50;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, lp_mode = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic rst_int_o, rst_ext_n, irq;
  int n_chk = 0, n_bad = 0;

  wdog_timer #(.TICKS_PER_HALF(TPH), .HOLD_TICKS(HOLD), .PDN_TICKS(PDN)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lp_mode(lp_mode), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_int_o(rst_int_o), .rst_ext_n(rst_ext_n), .irq(irq));

  always #4 clk = ~clk;

  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #1 tick = (k % TPH == TPH - 1);
      k++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset(input bit clr_misc);
    @(negedge clk); rst_n = 1'b0; lp_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    if (clr_misc) wr(4'h8, 16'h0000);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string req);
    bus_addr = a; #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  // sel: 0 rst_int_o high, 1 rst_ext_n low, 2 irq high, 3 rst_int_o low
  function automatic bit cond(input int sel);
    case (sel)
      0: return rst_int_o;
      1: return !rst_ext_n;
      2: return irq;
      default: return !rst_int_o;
    endcase
  endfunction

  task automatic ticks_until(input int sel, input int limit, output int n);
    n = 0;
    while (!cond(sel) && n < limit) begin
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_ticks(input int k);
    int n = 0;
    while (n < k) begin
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_values;
    do_reset(1'b0);
    rd(4'h0, 16'h0030, "R1 ctrl");
    rd(4'h2, 16'h0000, "R1 svc");
    rd(4'h4, 16'h0000, "R1 status");
    rd(4'h6, 16'h0000, "R1 icr");
    rd(4'h8, 16'h0001, "R1 misc");
    chk(!rst_int_o && rst_ext_n && !irq, "R1 outputs", {rst_int_o, rst_ext_n, irq}, 3'b010);
  endtask

  task automatic t_timeout_int;
    int n;
    do_reset(1'b1);
    wr(4'h0, 16'h0334);
    ticks_until(0, 200, n);
    chk(n == 16, "R2 period", n, 16);
    chk(rst_ext_n, "R2 ext idle", rst_ext_n, 1);
    rd(4'h4, 16'h0002, "R6 timeout cause");
    ticks_until(3, 50, n);
    chk(n == HOLD, "R9 hold", n, HOLD);
  endtask

  task automatic t_service;
    int n;
    do_reset(1'b1);
    wr(4'h0, 16'h0334);
    wait_ticks(10);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks_until(0, 200, n);
    chk(n == 16, "R3 reload", n, 16);
    do_reset(1'b1);
    wr(4'h0, 16'h0334);
    wait_ticks(10);
    wr(4'h2, 16'hAAAA); wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    ticks_until(0, 200, n);
    chk(n >= 4 && n <= 6, "R4 no reload", n, 5);
  endtask

  task automatic t_sticky;
    int n;
    do_reset(1'b1);
    wr(4'h0, 16'h0334);
    wr(4'h0, 16'h0330);
    rd(4'h0, 16'h0334, "R5 enable readback");
    ticks_until(0, 200, n);
    chk(n >= 15 && n <= 16, "R5 still counting", n, 16);
  endtask

  task automatic t_ext_action;
    int n;
    do_reset(1'b1);
    wr(4'h0, 16'h033C);
    ticks_until(1, 200, n);
    chk(n == 16, "R7 ext period", n, 16);
    chk(!rst_int_o, "R7 int idle", rst_int_o, 0);
    rd(4'h4, 16'h0002, "R6 ext cause");
    n = 0;
    while (!rst_ext_n && n < 50) begin
      if (tick) n++;
      @(negedge clk);
    end
    chk(n == HOLD, "R9 ext hold", n, HOLD);
  endtask

  task automatic t_sw_reset;
    do_reset(1'b1);
    wr(4'h0, 16'h0020);
    chk(rst_int_o && rst_ext_n, "R8 int request", {rst_int_o, rst_ext_n}, 2'b11);
    rd(4'h4, 16'h0001, "R6 sw cause");
    rd(4'h0, 16'h0030, "R8 bits read 1");
    do_reset(1'b1);
    wr(4'h0, 16'h0010);
    chk(!rst_int_o && !rst_ext_n, "R8 ext request", {rst_int_o, rst_ext_n}, 2'b00);
  endtask

  task automatic t_irq;
    int n;
    do_reset(1'b1);
    wr(4'h6, 16'h8002);
    wr(4'h0, 16'h0534);
    ticks_until(2, 200, n);
    chk(n == 12, "R10 lead", n, 12);
    rd(4'h6, 16'hC002, "R10 flag set");
    wr(4'h6, 16'hC002);
    chk(!irq, "R10 cleared", irq, 0);
    rd(4'h6, 16'h8002, "R10 flag clear");
    do_reset(1'b1);
    wr(4'h6, 16'h0002);
    wr(4'h0, 16'h0534);
    ticks_until(2, 22, n);
    chk(n == 22 && !irq, "R10 disabled", n, 22);
    rd(4'h6, 16'h0002, "R10 disabled flag");
  endtask

  task automatic t_lowpower;
    int n;
    do_reset(1'b1);
    wr(4'h0, 16'h0335);
    lp_mode = 1'b1;
    ticks_until(0, 30, n);
    chk(n == 30 && !rst_int_o, "R11 frozen", n, 30);
    lp_mode = 1'b0;
    ticks_until(0, 200, n);
    chk(n == 16, "R11 resume", n, 16);
    wr(4'h0, 16'h0334);
    rd(4'h0, 16'h0335, "R11 once set");
    do_reset(1'b1);
    wr(4'h0, 16'h0330);
    wr(4'h0, 16'h0331);
    rd(4'h0, 16'h0330, "R11 once clear");
  endtask

  task automatic t_new_period;
    int n;
    do_reset(1'b1);
    wr(4'h0, 16'h0334);
    wr(4'h0, 16'h0134);
    ticks_until(0, 200, n);
    chk(n >= 15 && n <= 16, "R12 old period", n, 16);
    ticks_until(3, 50, n);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks_until(0, 200, n);
    chk(n == 8, "R12 new period", n, 8);
  endtask

  task automatic t_powerdown;
    int lows = 0;
    do_reset(1'b0);
    repeat (PDN * TPH + 40) begin
      @(negedge clk);
      if (!rst_ext_n) lows++;
    end
    chk(lows == 1, "R13 pulse", lows, 1);
    lows = 0;
    do_reset(1'b1);
    wr(4'h8, 16'h0001);
    rd(4'h8, 16'h0000, "R13 stays off");
    repeat (PDN * TPH + 40) begin
      @(negedge clk);
      if (!rst_ext_n) lows++;
    end
    chk(lows == 0, "R13 disabled", lows, 0);
  endtask

  initial begin
    t_reset_values();
    t_timeout_int();
    t_service();
    t_sticky();
    t_ext_action();
    t_sw_reset();
    t_irq();
    t_lowpower();
    t_new_period();
    t_powerdown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule